// File: doc/BRIEF.md
# Erase-Block Lock Guard

This block decides whether a data write or a block erase is allowed to reach a given erase block. The flash array is split into 32 blocks. Each is 64 KB in byte mode or 32 K words in word mode. The command controller presents one command per cycle, with the upper address bits and a byte/word mode flag. One cycle later it gets back a permit or deny verdict. A refused operation sets a sticky error flag of the matching kind (data-write or erase). The flag stays set until a clear command is issued.

Every block has two lock bits:
- A stored lock bit. It stands in for the nonvolatile cell. After reset it takes the parameter `STORED_INIT`.
- A visible lock bit. This is the bit used for every decision and every query.

Reset forces all visible bits to locked. The real state appears only when an upload command copies the stored image into the visible bits. The lock command sets both bits of one block. The protect input gates only locked blocks: while it is low, locked blocks can still be modified.

An erase-all-unlocked command takes a snapshot of the blocks that are unlocked at that moment. It then hands their indices to the erase sequencer as a valid/ready stream, in ascending order. A beat stays on the stream until it is accepted. The sequencer may hold `ea_ready` low for any number of cycles without losing or reordering entries. `ea_valid` and the presented index do not depend on `ea_ready` in the same cycle.

Top module: `blk_lock_guard`

## Requirements
- R1: After reset every visible lock bit reads 1 (locked), `err_write`, `err_erase`, `chk_valid`, `qry_valid` and `ea_valid` are 0, and the stored image equals `STORED_INIT`.
- R2: Command `cmd_op`=4 (upload) copies every stored lock bit into the visible lock bit; a visible bit only ever changes from 1 to 0 through an upload.
- R3: Command `cmd_op`=3 (lock) sets both the stored and the visible lock bit of the addressed block; other blocks keep their bits.
- R4: `cmd_addr_hi` carries address bits 20..15; with `byte_mode`=1 the block index is `cmd_addr_hi[5:1]`, with `byte_mode`=0 it is `cmd_addr_hi[4:0]`.
- R5: A write (`cmd_op`=1) or erase (`cmd_op`=2) gives `chk_valid`=1 on the next cycle, with `chk_permit`=0 when `wr_protect` was 1 and the block's visible lock bit was 1.
- R6: A write or erase to an unlocked block, or to any block while `wr_protect` is 0, gives `chk_permit`=1; `chk_permit` is 0 whenever `chk_valid` is 0.
- R7: A refused write sets `err_write` and a refused erase sets `err_erase`; both hold until command `cmd_op`=7 (clear) clears them one cycle later; permitted operations leave them unchanged.
- R8: Command `cmd_op`=5 (query) gives `qry_valid`=1 and `qry_locked` equal to the block's visible lock bit on the next cycle; otherwise both are 0.
- R9: Command `cmd_op`=6 (erase all) with no list pending presents, from the next cycle, every block whose visible bit was 0 at the command, each once, in ascending index order, with `ea_last`=1 on the final entry only.
- R10: While `ea_valid`=1 and `ea_ready`=0 the same `ea_block` stays presented; an entry is removed only on a cycle with both high.
- R11: An erase-all command while a list is pending is ignored, and one issued when every block is locked presents nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_protect | input | 1 | Protect pin: 1 refuses changes to locked blocks |
| byte_mode | input | 1 | 1 = byte addressing, 0 = word addressing |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 idle, 1 write, 2 erase, 3 lock, 4 upload, 5 query, 6 erase all, 7 clear errors) |
| cmd_addr_hi | input | 6 | Address bits 20..15 |
| chk_valid | output | 1 | Verdict for a write or erase is present |
| chk_permit | output | 1 | Verdict: 1 allowed, 0 refused |
| err_write | output | 1 | Sticky refused-write flag |
| err_erase | output | 1 | Sticky refused-erase flag |
| qry_valid | output | 1 | Query answer present |
| qry_locked | output | 1 | Visible lock bit of the queried block |
| ea_valid | output | 1 | Erase-all list entry present |
| ea_ready | input | 1 | Sequencer accepts the entry |
| ea_block | output | 5 | Index of the block to erase |
| ea_last | output | 1 | Entry is the final one of the list |

## Verification
Verdicts, error flags, query answers and lock-bit updates all come from a single register stage. Each is due in the cycle after the command edge, and each is judged against the lock state from before that edge. The first erase-all entry appears one cycle after the command. Each following entry appears one cycle after the handshake that removed the one before it. The bench drives inputs just after the falling edge. A behavioural model advances on each rising edge using the inputs it sees there. The outputs are compared with the model at every falling edge, so each result is sampled exactly one register stage after its cause.

// File: rtl/blg_pkg.sv
package blg_pkg;
  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ERASE     = 3'd2,
    OP_LOCK      = 3'd3,
    OP_UPLOAD    = 3'd4,
    OP_QUERY     = 3'd5,
    OP_ERASE_ALL = 3'd6,
    OP_CLR_ERR   = 3'd7
  } blg_op_e;
endpackage

// File: rtl/blg_addr_map.sv
module blg_addr_map #(
  parameter int BLK_W = 5
) (
  input  logic             byte_mode,
  input  logic [BLK_W:0]   addr_hi,
  output logic [BLK_W-1:0] blk
);
  // byte addressing: block bits sit one place higher than in word addressing
  always_comb begin
    if (byte_mode) blk = addr_hi[BLK_W:1];
    else           blk = addr_hi[BLK_W-1:0];
  end
endmodule

// File: rtl/blg_lock_store.sv
module blg_lock_store #(
  parameter int                     BLK_W       = 5,
  parameter logic [(2**BLK_W)-1:0]  STORED_INIT = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     do_lock,
  input  logic                     do_upload,
  input  logic                     do_query,
  input  logic [BLK_W-1:0]         blk,
  output logic [(2**BLK_W)-1:0]    vis_lock,
  output logic                     qry_valid,
  output logic                     qry_locked
);
  localparam int N = 2**BLK_W;

  logic [N-1:0] nv_q;
  logic [N-1:0] vis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q  <= STORED_INIT;
      vis_q <= '1;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (do_lock && (blk == BLK_W'(i))) begin
          nv_q[i]  <= 1'b1;
          vis_q[i] <= 1'b1;
        end else if (do_upload) begin
          vis_q[i] <= nv_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qry_valid  <= 1'b0;
      qry_locked <= 1'b0;
    end else begin
      qry_valid  <= do_query;
      qry_locked <= do_query & vis_q[blk];
    end
  end

  assign vis_lock = vis_q;

  // R2: a visible bit can only drop through an upload
  assert_unlock_only_by_upload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(vis_q) & ~vis_q)) |-> $past(do_upload));

  // R3: lock sets both images of the addressed block
  assert_lock_sets_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(do_lock) |-> (vis_q[$past(blk)] && nv_q[$past(blk)]));

  // R8: a query answer is present exactly one cycle after the query
  assert_query_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_query |=> qry_valid);
endmodule

// File: rtl/blg_gate.sv
module blg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic do_write,
  input  logic do_erase,
  input  logic do_clr,
  input  logic wp,
  input  logic locked,
  output logic chk_valid,
  output logic chk_permit,
  output logic err_write,
  output logic err_erase
);
  logic deny;
  assign deny = wp & locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_valid  <= 1'b0;
      chk_permit <= 1'b0;
      err_write  <= 1'b0;
      err_erase  <= 1'b0;
    end else begin
      chk_valid  <= do_write | do_erase;
      chk_permit <= (do_write | do_erase) & ~deny;
      if (do_clr) begin
        err_write <= 1'b0;
        err_erase <= 1'b0;
      end else begin
        if (do_write && deny) err_write <= 1'b1;
        if (do_erase && deny) err_erase <= 1'b1;
      end
    end
  end

  // R5: protected and locked gives a refusal
  assert_refuse_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((do_write || do_erase) && wp && locked) |=> (chk_valid && !chk_permit));

  // R6: no permit without a verdict
  assert_permit_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_permit |-> chk_valid);

  // R7: an error flag rises only with a refusal of its own kind
  assert_werr_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_write) |-> ($past(do_write) && !chk_permit));
  assert_eerr_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_erase) |-> ($past(do_erase) && !chk_permit));
endmodule

// File: rtl/blg_sweep.sv
module blg_sweep #(
  parameter int BLK_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [(2**BLK_W)-1:0]  unlocked,
  output logic                   valid,
  input  logic                   ready,
  output logic [BLK_W-1:0]       blk,
  output logic                   last
);
  localparam int N = 2**BLK_W;

  logic [N-1:0] pending_q;
  logic [N-1:0] first;

  assign valid = |pending_q;
  assign first = pending_q & (~pending_q + N'(1));
  assign last  = valid && ((pending_q & ~first) == '0);

  // one-hot to index: each index bit is an OR over the positions that carry it
  for (genvar b = 0; b < BLK_W; b++) begin : g_enc
    logic [N-1:0] sel;
    always_comb begin
      for (int i = 0; i < N; i++) sel[i] = 1'((i >> b) & 1);
    end
    assign blk[b] = |(first & sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
    end else if (!valid) begin
      if (start) pending_q <= unlocked;
    end else if (ready) begin
      pending_q <= pending_q & ~first;
    end
  end

  // R10: a stalled entry is held unchanged
  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(blk)));

  // R9: each accepted beat removes exactly one entry
  assert_one_per_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> ($countones(pending_q) == $countones($past(pending_q)) - 1));

  // R9: indices rise across a list
  assert_ascending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !last) |=> (valid && (blk > $past(blk))));

  // R11: a pending list is not replaced by a new start
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (pending_q == $past(pending_q)));
endmodule

// File: rtl/blk_lock_guard.sv
module blk_lock_guard
  import blg_pkg::*;
#(
  parameter int                    BLK_W       = 5,
  parameter logic [(2**BLK_W)-1:0] STORED_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_protect,
  input  logic             byte_mode,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [BLK_W:0]   cmd_addr_hi,
  output logic             chk_valid,
  output logic             chk_permit,
  output logic             err_write,
  output logic             err_erase,
  output logic             qry_valid,
  output logic             qry_locked,
  output logic             ea_valid,
  input  logic             ea_ready,
  output logic [BLK_W-1:0] ea_block,
  output logic             ea_last
);
  localparam int N = 2**BLK_W;

  blg_op_e          op;
  logic [BLK_W-1:0] blk;
  logic [N-1:0]     vis_lock;
  logic             do_write, do_erase, do_lock, do_upload;
  logic             do_query, do_sweep, do_clr;

  assign op        = blg_op_e'(cmd_op);
  assign do_write  = cmd_valid && (op == OP_WRITE);
  assign do_erase  = cmd_valid && (op == OP_ERASE);
  assign do_lock   = cmd_valid && (op == OP_LOCK);
  assign do_upload = cmd_valid && (op == OP_UPLOAD);
  assign do_query  = cmd_valid && (op == OP_QUERY);
  assign do_sweep  = cmd_valid && (op == OP_ERASE_ALL);
  assign do_clr    = cmd_valid && (op == OP_CLR_ERR);

  blg_addr_map #(.BLK_W(BLK_W)) u_map (
    .byte_mode (byte_mode),
    .addr_hi   (cmd_addr_hi),
    .blk       (blk)
  );

  blg_lock_store #(.BLK_W(BLK_W), .STORED_INIT(STORED_INIT)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .do_lock    (do_lock),
    .do_upload  (do_upload),
    .do_query   (do_query),
    .blk        (blk),
    .vis_lock   (vis_lock),
    .qry_valid  (qry_valid),
    .qry_locked (qry_locked)
  );

  blg_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .do_write   (do_write),
    .do_erase   (do_erase),
    .do_clr     (do_clr),
    .wp         (wr_protect),
    .locked     (vis_lock[blk]),
    .chk_valid  (chk_valid),
    .chk_permit (chk_permit),
    .err_write  (err_write),
    .err_erase  (err_erase)
  );

  blg_sweep #(.BLK_W(BLK_W)) u_sweep (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (do_sweep),
    .unlocked (~vis_lock),
    .valid    (ea_valid),
    .ready    (ea_ready),
    .blk      (ea_block),
    .last     (ea_last)
  );

  // R6: with protect low every write or erase is permitted
  assert_unprotected_permit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((do_write || do_erase) && !wr_protect) |=> chk_permit);

  // R1: nothing is presented in the first cycle out of reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!ea_valid && !chk_valid && !qry_valid));
endmodule

// File: tb/blk_lock_guard_tb_top.sv
module blk_lock_guard_tb_top;
  import blg_pkg::*;

  localparam int CLK_PERIOD_NS = 10;
  localparam int BW = 5;
  localparam int NB = 32;
  localparam logic [31:0] NV_IMG = 32'hA500_0F03;

  logic clk, rst_n, wr_protect, byte_mode, cmd_valid, ea_ready;
  logic [2:0] cmd_op;
  logic [BW:0] cmd_addr_hi;
  logic chk_valid, chk_permit, err_write, err_erase, qry_valid, qry_locked;
  logic ea_valid, ea_last;
  logic [BW-1:0] ea_block;

  blk_lock_guard #(.BLK_W(BW), .STORED_INIT(NV_IMG)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_protect(wr_protect), .byte_mode(byte_mode),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr_hi(cmd_addr_hi),
    .chk_valid(chk_valid), .chk_permit(chk_permit), .err_write(err_write),
    .err_erase(err_erase), .qry_valid(qry_valid), .qry_locked(qry_locked),
    .ea_valid(ea_valid), .ea_ready(ea_ready), .ea_block(ea_block), .ea_last(ea_last)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD_NS/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state
  bit m_vis[NB];
  bit m_nv[NB];
  bit e_cv, e_cp, e_we, e_ee, e_qv, e_ql;
  int ea_q[$];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int blk_of(input bit bm, input int hi);
    if (bm) return (hi / 2) % NB;
    return hi % NB;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        m_vis[i] = 1'b1;
        m_nv[i]  = NV_IMG[i];
      end
      e_cv = 0; e_cp = 0; e_we = 0; e_ee = 0; e_qv = 0; e_ql = 0;
      ea_q.delete();
    end else begin
      int b;
      bit lk, deny, busy;
      b    = blk_of(byte_mode, int'(cmd_addr_hi));
      lk   = m_vis[b];
      deny = wr_protect && lk;
      busy = ea_q.size() > 0;
      e_cv = 0; e_cp = 0; e_qv = 0; e_ql = 0;
      if (busy && ea_ready) void'(ea_q.pop_front());
      if (cmd_valid) begin
        case (cmd_op)
          3'd1: begin e_cv = 1; e_cp = !deny; if (deny) e_we = 1; end
          3'd2: begin e_cv = 1; e_cp = !deny; if (deny) e_ee = 1; end
          3'd3: begin m_vis[b] = 1; m_nv[b] = 1; end
          3'd4: for (int i = 0; i < NB; i++) m_vis[i] = m_nv[i];
          3'd5: begin e_qv = 1; e_ql = lk; end
          3'd6: if (!busy) begin
                  for (int i = 0; i < NB; i++) if (!m_vis[i]) ea_q.push_back(i);
                end
          3'd7: begin e_we = 0; e_ee = 0; end
          default: ;
        endcase
      end
    end
  end

  // every-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R5 chk_valid", int'(chk_valid), int'(e_cv));
      check("R6 chk_permit", int'(chk_permit), int'(e_cp));
      check("R7 err_write", int'(err_write), int'(e_we));
      check("R7 err_erase", int'(err_erase), int'(e_ee));
      check("R8 qry_valid", int'(qry_valid), int'(e_qv));
      check("R8 qry_locked", int'(qry_locked), int'(e_ql));
      check("R9 ea_valid", int'(ea_valid), int'(ea_q.size() > 0));
      if (ea_q.size() > 0) begin
        check("R10 ea_block", int'(ea_block), ea_q[0]);
        check("R9 ea_last", int'(ea_last), int'(ea_q.size() == 1));
      end
    end
  end

  task automatic issue(input logic [2:0] op, input int hi, input bit bm, input bit wp);
    @(negedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr_hi = hi[BW:0]; byte_mode = bm; wr_protect = wp;
    @(negedge clk); #1;
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  initial begin
    rst_n = 1'b0; wr_protect = 1'b0; byte_mode = 1'b0; cmd_valid = 1'b0;
    cmd_op = 3'd0; cmd_addr_hi = '0; ea_ready = 1'b0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 reset chk_valid", int'(chk_valid), 0);
    check("R1 reset ea_valid", int'(ea_valid), 0);
    check("R1 reset err_write", int'(err_write), 0);

    issue(3'd5, 0, 0, 0);  check("R1 block0 locked", int'(qry_locked), 1);
    issue(3'd5, 31, 0, 0); check("R1 block31 locked", int'(qry_locked), 1);
    issue(3'd6, 0, 0, 0);  check("R11 all locked, empty list", int'(ea_valid), 0);

    issue(3'd1, 2, 0, 1);  check("R5 refused write", int'(chk_permit), 0);
    check("R7 write error set", int'(err_write), 1);
    issue(3'd1, 2, 0, 0);  check("R6 unprotected write", int'(chk_permit), 1);

    issue(3'd4, 0, 0, 0);
    issue(3'd5, 0, 0, 0);  check("R2 upload block0", int'(qry_locked), 1);
    issue(3'd5, 2, 0, 0);  check("R2 upload block2", int'(qry_locked), 0);
    issue(3'd1, 2, 0, 1);  check("R6 unlocked permitted", int'(chk_permit), 1);

    issue(3'd5, 9 * 2, 1, 0); check("R4 byte-mode block9", int'(qry_locked), 1);
    issue(3'd5, 9, 0, 0);     check("R4 word-mode block9", int'(qry_locked), 1);
    issue(3'd5, 9, 1, 0);     check("R4 byte-mode block4", int'(qry_locked), 0);

    issue(3'd3, 5, 0, 0);
    issue(3'd5, 5, 0, 0);  check("R3 lock block5", int'(qry_locked), 1);
    issue(3'd5, 6, 0, 0);  check("R3 neighbour unchanged", int'(qry_locked), 0);
    issue(3'd2, 5, 0, 1);  check("R7 erase error set", int'(err_erase), 1);
    issue(3'd7, 0, 0, 0);  check("R7 cleared", int'(err_erase | err_write), 0);

    // sweep with stalls
    ea_ready = 1'b0;
    issue(3'd6, 0, 0, 0);
    check("R9 list starts", int'(ea_valid), 1);
    check("R9 first index", int'(ea_block), 2);
    idle(3);
    check("R10 held under stall", int'(ea_block), 2);
    issue(3'd6, 0, 0, 0);
    issue(3'd3, 12, 0, 0);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk); #1; ea_ready = (i % 3) != 1;
    end
    ea_ready = 1'b1;
    idle(4);
    check("R11 list drained", int'(ea_valid), 0);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      cmd_valid   = ($urandom % 4) != 0;
      cmd_op      = 3'($urandom % 8);
      cmd_addr_hi = (BW+1)'($urandom);
      byte_mode   = 1'($urandom);
      wr_protect  = 1'($urandom);
      ea_ready    = ($urandom % 3) != 0;
    end
    cmd_valid = 1'b0; ea_ready = 1'b1;
    idle(40);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD_NS * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule